// File: doc/BRIEF.md
# Single-Port RAM Slave for Classic Wishbone Cycles

This block is a Wishbone slave that holds a word-wide memory and answers classic single-transfer bus cycles. It is meant for masters that issue one transfer at a time and wait for the handshake. The memory is inferred as a synchronous single-port array. Its read output is registered, so a word is available only on the clock after its address was presented. A small state machine hides that latency from the master.

The controller has two states. In `ST_IDLE` it looks at the request on the bus. A valid write is stored in the array and acknowledged in the same cycle, and the state stays `ST_IDLE`. A valid read hands its address to the array and takes the transition `ST_IDLE -> ST_READ_ACK`. No acknowledge is given in that cycle, which is the stall cycle. In `ST_READ_ACK` the registered word drives `wb_dat_r` and `wb_ack` is raised. The transition `ST_READ_ACK -> ST_IDLE` is then taken unconditionally, including when the master has abandoned the cycle. A request whose byte selects are not all set is not a valid transfer: it gets an error response in `ST_IDLE` and never touches the array.

The address width and the data width in bytes are parameters. The memory holds 2^ADDR_W words.

Top module: `wbram_slave`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the controller is in `ST_IDLE`. `wb_ack` and `wb_err` are both low.
- R2: A valid read has `wb_cyc`=1, `wb_stb`=1, `wb_we`=0 and every bit of `wb_sel` set. In the cycle in which it is first presented, `wb_ack` is low. In the next cycle `wb_ack` is high and `wb_dat_r` holds the word last stored at `wb_adr`.
- R3: After a read acknowledge the controller is back in `ST_IDLE`. A read that follows immediately with strobe held high again gets one stall cycle before its acknowledge, so no two read acknowledges occur in consecutive cycles.
- R4: A valid write (`wb_we`=1, every bit of `wb_sel` set) presented in `ST_IDLE` is acknowledged in that same cycle. `wb_dat_w` is stored at `wb_adr` on that clock edge.
- R5: A write whose `wb_sel` is not all ones gets `wb_err`=1 and `wb_ack`=0 in the same cycle, and the stored word at its address is left unchanged.
- R6: A read whose `wb_sel` is not all ones gets `wb_err`=1 in the cycle it is presented, with no stall cycle and no acknowledge.
- R7: `wb_ack` and `wb_err` are never high together. Both are low in any cycle where `wb_cyc` or `wb_stb` is low. `wb_dat_r` is zero except while a read is being acknowledged.
- R8: If the master drops `wb_cyc` and `wb_stb` during the `ST_READ_ACK` cycle, no acknowledge is given and the controller returns to `ST_IDLE`. A following read behaves as in R2.
- R9: Every one of the 2^ADDR_W addresses is a distinct word. The lowest and the highest address hold independent values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_cyc | input | 1 | Bus cycle in progress |
| wb_stb | input | 1 | Transfer strobe |
| wb_we | input | 1 | 1 = write, 0 = read |
| wb_adr | input | ADDR_W | Word address |
| wb_dat_w | input | DATA_BYTES*8 | Write data |
| wb_sel | input | DATA_BYTES | Byte selects; only all ones is accepted |
| wb_dat_r | output | DATA_BYTES*8 | Read data, valid while a read is acknowledged |
| wb_ack | output | 1 | Transfer acknowledge |
| wb_err | output | 1 | Error response for a partial byte select |

## Verification
The bench goes after the stall cycle. A design that acknowledged reads at once would return the previous word or undefined data, and one that stayed in the read-acknowledge state would acknowledge twice. Back-to-back reads with strobe held high show whether the controller really returns to idle. An aborted read shows whether a stale acknowledge leaks out after the master has left. Partial-select writes are followed by reads of the same address, so a design that wrote anyway or acknowledged instead of erroring is caught. Partial-select reads check that the error comes without a stall.

// File: rtl/wbram_pkg.sv
package wbram_pkg;

    // Controller states of the classic-cycle RAM slave
    typedef enum logic [0:0] {
        ST_IDLE     = 1'b0,
        ST_READ_ACK = 1'b1
    } ctl_state_t;

endpackage

// File: rtl/wbram_req_decode.sv
// Classifies the request currently on the bus.
module wbram_req_decode #(
    parameter int SEL_W = 4
) (
    input  logic             cyc,
    input  logic             stb,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    output logic             req_read,
    output logic             req_write,
    output logic             req_bad
);

    logic active;
    logic full_word;

    always_comb begin
        active    = cyc && stb;
        full_word = &sel;
        req_read  = active && !we && full_word;
        req_write = active &&  we && full_word;
        req_bad   = active && !full_word;
    end

endmodule

// File: rtl/wbram_store.sv
// Word-wide synchronous single-port memory with registered read.
module wbram_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr] <= wdata;
        end
        if (rd_en) begin
            rdata <= mem[addr];
        end
    end

endmodule

// File: rtl/wbram_ctrl.sv
// Two-state response controller.
module wbram_ctrl
    import wbram_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc,
    input  logic       stb,
    input  logic       req_read,
    input  logic       req_write,
    input  logic       req_bad,
    output logic       ack,
    output logic       err,
    output logic       mem_rd,
    output logic       mem_wr,
    output logic       rdata_sel,
    output ctl_state_t state
);

    ctl_state_t state_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next state and outputs
    always_comb begin
        state_nx  = state;
        ack       = 1'b0;
        err       = 1'b0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        rdata_sel = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_bad) begin
                    err = 1'b1;
                end else if (req_write) begin
                    mem_wr = 1'b1;
                    ack    = 1'b1;
                end else if (req_read) begin
                    mem_rd   = 1'b1;
                    state_nx = ST_READ_ACK;
                end
            end
            ST_READ_ACK: begin
                ack       = cyc && stb;
                rdata_sel = cyc && stb;
                state_nx  = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/wbram_slave.sv
// Classic-cycle Wishbone slave around a one-cycle-latency RAM.
module wbram_slave
    import wbram_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wb_cyc,
    input  logic                    wb_stb,
    input  logic                    wb_we,
    input  logic [ADDR_W-1:0]       wb_adr,
    input  logic [DATA_BYTES*8-1:0] wb_dat_w,
    input  logic [DATA_BYTES-1:0]   wb_sel,
    output logic [DATA_BYTES*8-1:0] wb_dat_r,
    output logic                    wb_ack,
    output logic                    wb_err
);

    localparam int DATA_W = DATA_BYTES * 8;

    logic              req_read, req_write, req_bad;
    logic              mem_rd, mem_wr, rdata_sel;
    logic [DATA_W-1:0] mem_q;
    ctl_state_t        ctl_state;

    wbram_req_decode #(.SEL_W(DATA_BYTES)) u_dec (
        .cyc       (wb_cyc),
        .stb       (wb_stb),
        .we        (wb_we),
        .sel       (wb_sel),
        .req_read  (req_read),
        .req_write (req_write),
        .req_bad   (req_bad)
    );

    wbram_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc       (wb_cyc),
        .stb       (wb_stb),
        .req_read  (req_read),
        .req_write (req_write),
        .req_bad   (req_bad),
        .ack       (wb_ack),
        .err       (wb_err),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .rdata_sel (rdata_sel),
        .state     (ctl_state)
    );

    wbram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .wr_en (mem_wr),
        .rd_en (mem_rd),
        .addr  (wb_adr),
        .wdata (wb_dat_w),
        .rdata (mem_q)
    );

    always_comb begin
        wb_dat_r = rdata_sel ? mem_q : '0;
    end

endmodule

// File: rtl/wbram_slave_chk.sv
module wbram_slave_chk
    import wbram_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wb_cyc,
    input logic             wb_stb,
    input logic             wb_we,
    input logic [SEL_W-1:0] wb_sel,
    input logic             wb_ack,
    input logic             wb_err,
    input ctl_state_t       ctl_state
);

    // R1
    always_comb begin
        if (!rst_n) begin
            rst_quiet_chk: assert (!wb_ack && !wb_err && ctl_state == ST_IDLE);
        end
    end

    // R7
    ack_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_ack && wb_err));

    // R7
    idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_cyc && wb_stb) |-> (!wb_ack && !wb_err));

    // R2
    read_ack_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_ack && !wb_we) |-> $past(wb_cyc && wb_stb && !wb_we));

    // R3
    no_double_read_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_ack && !wb_we) |=> !(wb_ack && !wb_we));

    // R4
    write_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_state == ST_IDLE && wb_cyc && wb_stb && wb_we && (&wb_sel)) |-> wb_ack);

    // R5
    err_only_partial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_err |-> !(&wb_sel));

endmodule

bind wbram_slave wbram_slave_chk #(.SEL_W(DATA_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wb_cyc    (wb_cyc),
    .wb_stb    (wb_stb),
    .wb_we     (wb_we),
    .wb_sel    (wb_sel),
    .wb_ack    (wb_ack),
    .wb_err    (wb_err),
    .ctl_state (ctl_state)
);

// File: tb/wbram_slave_test.sv
`timescale 1ns/1ps
module wbram_slave_test;

    localparam int AW    = 8;
    localparam int NB    = 4;
    localparam int DW    = NB * 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wb_cyc = 1'b0, wb_stb = 1'b0, wb_we = 1'b0;
    logic [AW-1:0] wb_adr = '0;
    logic [DW-1:0] wb_dat_w = '0;
    logic [NB-1:0] wb_sel = '0;
    logic [DW-1:0] wb_dat_r;
    logic          wb_ack, wb_err;

    int n_tests = 0;
    int n_fail  = 0;
    logic [DW-1:0] model [DEPTH];

    always #4 clk = ~clk;

    wbram_slave #(.ADDR_W(AW), .DATA_BYTES(NB)) uut (
        .clk(clk), .rst_n(rst_n), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
        .wb_adr(wb_adr), .wb_dat_w(wb_dat_w), .wb_sel(wb_sel),
        .wb_dat_r(wb_dat_r), .wb_ack(wb_ack), .wb_err(wb_err)
    );

    function automatic logic [NB-1:0] full_sel();
        return {NB{1'b1}};
    endfunction

    function automatic logic [NB-1:0] partial_sel(int unsigned r);
        return NB'(r % ((1 << NB) - 1));
    endfunction

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic bus_idle();
        wb_cyc = 1'b0; wb_stb = 1'b0; wb_we = 1'b0; wb_sel = '0;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input logic [NB-1:0] s, input string req);
        @(negedge clk);
        wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = 1'b1; wb_adr = a; wb_dat_w = d; wb_sel = s;
        #1;
        if (&s) begin
            check(wb_ack && !wb_err, req, {30'd0, wb_ack, wb_err}, 32'd2);
            model[a] = d;
        end else begin
            check(wb_err && !wb_ack, req, {30'd0, wb_ack, wb_err}, 32'd1);
        end
        @(negedge clk);
        bus_idle();
        #1;
        check(!wb_ack && !wb_err && wb_dat_r == '0, "R7",
              {wb_ack, wb_err, wb_dat_r[29:0]}, '0);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input string req);
        @(negedge clk);
        wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = 1'b0; wb_adr = a; wb_sel = full_sel();
        #1;
        check(!wb_ack && !wb_err, {req, " stall"}, {30'd0, wb_ack, wb_err}, '0);
        @(negedge clk);
        #1;
        check(wb_ack && !wb_err && wb_dat_r == model[a], req, wb_dat_r, model[a]);
        @(negedge clk);
        bus_idle();
    endtask

    task automatic do_bad_read(input logic [AW-1:0] a, input logic [NB-1:0] s);
        @(negedge clk);
        wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = 1'b0; wb_adr = a; wb_sel = s;
        #1;
        check(wb_err && !wb_ack, "R6", {30'd0, wb_ack, wb_err}, 32'd1);
        @(negedge clk);
        bus_idle();
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        #1;
        // R1: outputs quiet in reset
        check(!wb_ack && !wb_err, "R1", {30'd0, wb_ack, wb_err}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!wb_ack && !wb_err, "R1", {30'd0, wb_ack, wb_err}, '0);

        // R4: fill every word
        for (int i = 0; i < DEPTH; i++) begin
            do_write(AW'(i), $urandom(), full_sel(), "R4");
        end

        // R9: lowest and highest addresses are independent
        do_write('0, 32'hA5A5_0001, full_sel(), "R4");
        do_write('1, 32'h5A5A_FFFE, full_sel(), "R4");
        do_read('0, "R9");
        do_read('1, "R9");

        // R2: directed read
        do_read(AW'(17), "R2");

        // R5: partial write leaves the word unchanged
        do_write(AW'(17), 32'hDEAD_BEEF, 4'b0111, "R5");
        do_read(AW'(17), "R5");

        // R6: partial read, no stall
        do_bad_read(AW'(3), 4'b0001);

        // R3: back-to-back reads with strobe held
        @(negedge clk);
        wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = 1'b0; wb_adr = AW'(5); wb_sel = full_sel();
        @(negedge clk);
        #1;
        check(wb_ack && wb_dat_r == model[5], "R3", wb_dat_r, model[5]);
        @(negedge clk);
        wb_adr = AW'(6);
        #1;
        check(!wb_ack, "R3", {31'd0, wb_ack}, '0);
        @(negedge clk);
        #1;
        check(wb_ack && wb_dat_r == model[6], "R3", wb_dat_r, model[6]);
        @(negedge clk);
        bus_idle();

        // R8: abandon read in the acknowledge cycle
        @(negedge clk);
        wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = 1'b0; wb_adr = AW'(9); wb_sel = full_sel();
        @(negedge clk);
        bus_idle();
        #1;
        check(!wb_ack && !wb_err, "R8", {30'd0, wb_ack, wb_err}, '0);
        do_read(AW'(9), "R8");

        // Random mix
        for (int k = 0; k < 400; k++) begin
            int unsigned op;
            logic [AW-1:0] a;
            op = $urandom() % 5;
            a  = AW'($urandom());
            case (op)
                0, 1: do_read(a, "R2");
                2:    do_write(a, $urandom(), full_sel(), "R4");
                3:    do_write(a, $urandom(), partial_sel($urandom()), "R5");
                default: do_bad_read(a, partial_sel($urandom()));
            endcase
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule